// File: doc/BRIEF.md
# Internal IO and PCI Configuration Address Decoder

This block turns requests aimed at a non-memory internal address space into physical addresses. The request address is shifted right by three bits. The top bits of the shifted value select a space, and the remaining bits give an offset within that space. For the register space, an external lookup supplies a register index. For the IO space, each port maps to a physical IO address. Ports in the configuration data window can instead map to PCI configuration space, using the two-port configuration mechanism. The offset of a register-space request is passed out to that external lookup.

A 32-bit configuration address register is held inside the block. A dword write to port 0xCF8 loads it. A dword access to 0xCF8 is also reported as an internal register access. Accesses to the data window at 0xCFC..0xCFF become configuration-space addresses only while bit 31 of that register is set. The decode is combinational. Only the configuration address register is clocked.

Top module: `intio_decoder`

## Requirements
- R1: Synchronous active-high reset clears the configuration address register to zero. After reset, a read of port 0xCFC maps to the IO space (0x2000_0000_0000_0000 | 0xCFC).
- R2: The space code is `req_addr[63:61]` and the offset is `req_addr[60:3]`. Address bits 2:0 do not affect the result. The space codes are 0 = identification, 1 = register, 2 = IO, and 3..7 are unrecognized.
- R3: An identification-space or unrecognized-space request raises `err_o`. In that case `paddr_o` is 0 and the other flags are 0.
- R4: An IO request whose offset is 0x10000 or larger raises `err_o` with `paddr_o` = 0. Such a request never loads the configuration register.
- R5: An IO request to port 0xCF8 with `req_size` = 4 sets `int_reg_o` with `paddr_o` = 0x200, the configuration register index 0x40 times 8. `uncache_o` stays clear.
- R6: An IO request to port 0xCFC..0xCFF while configuration bit 31 is set gives `paddr_o` = 0x3000_0000_0000_0000 | {cfg[30:2], 2'b00} | port[1:0], with `uncache_o` set.
- R7: Every other IO request gives `paddr_o` = 0x2000_0000_0000_0000 | port, with `uncache_o` set. This covers the data window while bit 31 is clear and 0xCF8 with a size other than 4.
- R8: A register-space request with `msr_hit_i` low raises `gp_fault_o` with `paddr_o` = 0.
- R9: A register-space request with `msr_hit_i` high gives `paddr_o` = `msr_idx_i` * 8 with `int_reg_o` set. For every register-space request, `msr_num_o` equals the offset.
- R10: A valid write of size 4 to IO port 0xCF8 loads `req_wdata[31:0]` into the configuration register on the next clock edge. Reads, other sizes and other ports leave the register unchanged.
- R11: With `req_valid` low, `paddr_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 64 | Internal-space request address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| msr_num_o | output | 58 | Register-space offset sent to the external lookup |
| msr_hit_i | input | 1 | External lookup found a mapping |
| msr_idx_i | input | 16 | Register index from the external lookup |
| paddr_o | output | 64 | Physical address |
| uncache_o | output | 1 | Access is uncacheable |
| int_reg_o | output | 1 | Access targets an internal register |
| gp_fault_o | output | 1 | General-protection fault |
| err_o | output | 1 | Unsupported space or port out of range |

## Verification
The only internal state is the configuration address register, and it can only be seen through the data window. A wrong value appears as a wrong configuration-space address on the first read of 0xCFC..0xCFF after the bad load. A lost enable bit appears as an IO address instead of a configuration-space address. The bench therefore reads the data window after every write pattern to 0xCF8, including writes that must not load the register, so that an update or a miss appears within one cycle.

// File: rtl/intio_pkg.sv
package intio_pkg;
    localparam int ADDR_W  = 64;
    localparam int PADDR_W = 64;
    localparam int PFX_W   = 3;
    localparam int SH_W    = ADDR_W - 3;
    localparam int OFF_W   = SH_W - PFX_W;
    localparam int PORT_W  = 16;
    localparam int CFG_W   = 32;
    localparam int IDX_W   = 16;

    typedef enum logic [1:0] {
        SP_IDENT = 2'd0,
        SP_REG   = 2'd1,
        SP_IO    = 2'd2,
        SP_OTHER = 2'd3
    } space_e;

    typedef struct packed {
        logic [PADDR_W-1:0] paddr;
        logic               uncache;
        logic               int_reg;
        logic               gp_fault;
        logic               err;
    } result_t;

    function automatic result_t res_zero();
        result_t r;
        r = '0;
        return r;
    endfunction

    function automatic space_e decode_space(input logic [PFX_W-1:0] code);
        case (code)
            3'd0:    return SP_IDENT;
            3'd1:    return SP_REG;
            3'd2:    return SP_IO;
            default: return SP_OTHER;
        endcase
    endfunction
endpackage

// File: rtl/intio_prefix_split.sv
module intio_prefix_split
    import intio_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PW  = PFX_W,
    localparam int SW = AW - 3,
    localparam int OW = SW - PW
) (
    input  logic [AW-1:0] addr_i,
    output space_e        space_o,
    output logic [OW-1:0] offset_o
);
    logic [SW-1:0] shifted;

    always_comb begin
        shifted  = SW'(addr_i >> 3);
        space_o  = decode_space(shifted[SW-1 -: PW]);
        offset_o = shifted[OW-1:0];
    end
endmodule

// File: rtl/intio_cfg_reg.sv
module intio_cfg_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= '0;
        else if (load_i)
            cfg_o <= data_i;
    end
endmodule

// File: rtl/intio_io_map.sv
module intio_io_map
    import intio_pkg::*;
#(
    parameter int                OW       = OFF_W,
    parameter int                CW       = CFG_W,
    parameter logic [PADDR_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000,
    parameter int                CFG_IDX  = 'h40,
    parameter int                REG_BYTES = 8,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
    input  logic [OW-1:0] offset_i,
    input  logic [3:0]    size_i,
    input  logic [CW-1:0] cfg_i,
    output logic          addr_sel_o,
    output result_t       res_o
);
    logic [PORT_W-1:0] port;
    logic              in_range;
    logic              win_hit;

    always_comb begin
        port       = offset_i[PORT_W-1:0];
        in_range   = (offset_i[OW-1:PORT_W] == '0);
        win_hit    = ({port[PORT_W-1:2], 2'b00} == DATA_PORT);
        addr_sel_o = in_range && (port == ADDR_PORT) && (size_i == 4'd4);
        res_o      = res_zero();
        if (!in_range) begin
            res_o.err = 1'b1;
        end else if (addr_sel_o) begin
            res_o.int_reg = 1'b1;
            res_o.paddr   = PADDR_W'(CFG_IDX * REG_BYTES);
        end else if (win_hit && cfg_i[CW-1]) begin
            res_o.uncache = 1'b1;
            res_o.paddr   = CFG_BASE
                          | PADDR_W'({cfg_i[CW-2:2], 2'b00})
                          | PADDR_W'(port[1:0]);
        end else begin
            res_o.uncache = 1'b1;
            res_o.paddr   = IO_BASE | PADDR_W'(port);
        end
    end
endmodule

// File: rtl/intio_decoder.sv
module intio_decoder
    import intio_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int PW        = PFX_W,
    parameter int IW        = IDX_W,
    parameter int REG_BYTES = 8,
    localparam int OW       = AW - 3 - PW,
    localparam int SHIFT    = $clog2(REG_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [3:0]         req_size,
    input  logic [CFG_W-1:0]   req_wdata,
    output logic [OW-1:0]      msr_num_o,
    input  logic               msr_hit_i,
    input  logic [IW-1:0]      msr_idx_i,
    output logic [PADDR_W-1:0] paddr_o,
    output logic               uncache_o,
    output logic               int_reg_o,
    output logic               gp_fault_o,
    output logic               err_o
);
    space_e             space;
    logic [OW-1:0]      offset;
    logic [CFG_W-1:0]   cfg_q;
    logic               addr_sel;
    logic               cfg_we;
    result_t            io_res;
    result_t            res;

    intio_prefix_split #(.AW(AW), .PW(PW)) u_split (
        .addr_i   (req_addr),
        .space_o  (space),
        .offset_o (offset)
    );

    intio_io_map #(.OW(OW), .CW(CFG_W), .REG_BYTES(REG_BYTES)) u_io (
        .offset_i   (offset),
        .size_i     (req_size),
        .cfg_i      (cfg_q),
        .addr_sel_o (addr_sel),
        .res_o      (io_res)
    );

    assign cfg_we = req_valid && req_write && (space == SP_IO) && addr_sel;

    intio_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (cfg_we),
        .data_i (req_wdata),
        .cfg_o  (cfg_q)
    );

    always_comb begin
        res = res_zero();
        if (req_valid) begin
            case (space)
                SP_IO:  res = io_res;
                SP_REG: begin
                    if (msr_hit_i) begin
                        res.int_reg = 1'b1;
                        res.paddr   = PADDR_W'(msr_idx_i) << SHIFT;
                    end else begin
                        res.gp_fault = 1'b1;
                    end
                end
                default: res.err = 1'b1;
            endcase
        end
    end

    assign msr_num_o  = offset;
    assign paddr_o    = res.paddr;
    assign uncache_o  = res.uncache;
    assign int_reg_o  = res.int_reg;
    assign gp_fault_o = res.gp_fault;
    assign err_o      = res.err;
endmodule

// File: rtl/intio_decoder_chk.sv
module intio_decoder_chk
    import intio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [3:0]         req_size,
    input logic [CFG_W-1:0]   req_wdata,
    input logic [PADDR_W-1:0] paddr_o,
    input logic               uncache_o,
    input logic               int_reg_o,
    input logic               gp_fault_o,
    input logic               err_o,
    input logic [CFG_W-1:0]   cfg_q
);
    logic dword_cf8_wr;
    assign dword_cf8_wr = req_valid && req_write && req_size == 4'd4
                       && req_addr[63:61] == 3'd2
                       && req_addr[60:3] == 58'hCF8;

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (paddr_o == '0 && !uncache_o && !int_reg_o && !gp_fault_o && !err_o));

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({uncache_o, int_reg_o, gp_fault_o, err_o}));

    a_r4_err_no_addr: assert property (@(posedge clk) disable iff (rst)
        err_o |-> paddr_o == '0);

    a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        gp_fault_o |-> paddr_o == '0);

    a_r10_cfg_load: assert property (@(posedge clk) disable iff (rst)
        dword_cf8_wr |=> cfg_q == $past(req_wdata));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !dword_cf8_wr |=> $stable(cfg_q));
endmodule

bind intio_decoder intio_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .paddr_o    (paddr_o),
    .uncache_o  (uncache_o),
    .int_reg_o  (int_reg_o),
    .gp_fault_o (gp_fault_o),
    .err_o      (err_o),
    .cfg_q      (cfg_q)
);

// File: tb/intio_decoder_bench.sv
module intio_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] IO_B  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] CFG_B = 64'h3000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [63:0] req_addr;
    logic [3:0]  req_size;
    logic [31:0] req_wdata;
    logic [57:0] msr_num_o;
    logic        msr_hit_i;
    logic [15:0] msr_idx_i;
    logic [63:0] paddr_o;
    logic        uncache_o, int_reg_o, gp_fault_o, err_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] mcfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    intio_decoder u_intio_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .msr_num_o(msr_num_o), .msr_hit_i(msr_hit_i), .msr_idx_i(msr_idx_i),
        .paddr_o(paddr_o), .uncache_o(uncache_o), .int_reg_o(int_reg_o),
        .gp_fault_o(gp_fault_o), .err_o(err_o)
    );

    function automatic logic [63:0] io_addr(input logic [57:0] port);
        return {3'd2, port, 3'b000};
    endfunction

    task automatic step(input string tag, input logic v, input logic w,
                        input logic [63:0] a, input logic [3:0] sz,
                        input logic [31:0] wd, input logic hit, input logic [15:0] idx);
        logic [63:0] e_pa;
        logic e_uc, e_ir, e_gp, e_er;
        logic [2:0]  sp;
        logic [57:0] off;
        logic [15:0] port;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = sz;
        req_wdata = wd; msr_hit_i = hit; msr_idx_i = idx;
        sp = a[63:61]; off = a[60:3]; port = off[15:0];
        e_pa = '0; e_uc = 0; e_ir = 0; e_gp = 0; e_er = 0;
        if (v) begin
            if (sp == 3'd1) begin
                if (hit) begin e_ir = 1; e_pa = 64'(idx) * 8; end
                else e_gp = 1;
            end else if (sp == 3'd2) begin
                if (off >= 58'h10000) e_er = 1;
                else if (port == 16'hCF8 && sz == 4) begin e_ir = 1; e_pa = 64'h200; end
                else if (port >= 16'hCFC && port <= 16'hCFF && mcfg[31]) begin
                    e_uc = 1;
                    e_pa = CFG_B | 64'(mcfg[30:0] & 31'h7FFF_FFFC) | 64'(port[1:0]);
                end else begin e_uc = 1; e_pa = IO_B | 64'(port); end
            end else e_er = 1;
        end
        #1;
        tests++;
        if (paddr_o !== e_pa || uncache_o !== e_uc || int_reg_o !== e_ir ||
            gp_fault_o !== e_gp || err_o !== e_er) begin
            fails++;
            $display("FAIL %s: got pa=%h uc=%b ir=%b gp=%b er=%b, expected pa=%h uc=%b ir=%b gp=%b er=%b",
                     tag, paddr_o, uncache_o, int_reg_o, gp_fault_o, err_o,
                     e_pa, e_uc, e_ir, e_gp, e_er);
        end
        if (v && sp == 3'd1 && msr_num_o !== off) begin
            fails++;
            $display("FAIL %s (R9 msr_num): got %h expected %h", tag, msr_num_o, off);
        end
        if (!rst && v && w && sp == 3'd2 && off == 58'hCF8 && sz == 4) mcfg = wd;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        mcfg = '0;
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_addr = '0; req_size = '0;
        req_wdata = '0; msr_hit_i = 0; msr_idx_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11 idle and R1 reset state seen through the data window
        step("R11 idle",         0, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        step("R1 reset window",  1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        // R5 / R10 dword load of the address register
        step("R5 R10 cf8 write", 1, 1, io_addr(58'hCF8), 4, 32'h8000_1235, 0, 0);
        step("R6 window cfc",    1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        step("R6 window cfe",    1, 0, io_addr(58'hCFE), 2, 0, 0, 0);
        step("R6 window cff",    1, 0, io_addr(58'hCFF), 1, 0, 0, 0);
        // R10 reads and other sizes do not load
        step("R5 R10 cf8 read",  1, 0, io_addr(58'hCF8), 4, 32'h0000_0000, 0, 0);
        step("R6 R10 after read",1, 0, io_addr(58'hCFD), 1, 0, 0, 0);
        step("R7 R10 cf8 size2", 1, 1, io_addr(58'hCF8), 2, 32'h0000_0000, 0, 0);
        step("R6 R10 after sz2", 1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        // R4 out of range with low bits equal to 0xCF8 must not load
        step("R4 R10 range wr",  1, 1, io_addr(58'h1_0CF8), 4, 32'h0, 0, 0);
        step("R6 R10 after oor", 1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        step("R10 other port",   1, 1, io_addr(58'hCF9), 4, 32'h0, 0, 0);
        step("R6 R10 after cf9", 1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        // R7 enable bit cleared and ordinary ports
        step("R10 cf8 clear",    1, 1, io_addr(58'hCF8), 4, 32'h0000_ABCC, 0, 0);
        step("R7 window off",    1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        step("R7 port 60",       1, 0, io_addr(58'h60), 1, 0, 0, 0);
        step("R7 port ffff",     1, 0, io_addr(58'hFFFF), 1, 0, 0, 0);
        step("R4 port range",    1, 0, io_addr(58'h1_0000), 1, 0, 0, 0);
        // R2 low address bits ignored
        step("R2 low bits",      1, 0, io_addr(58'h70) | 64'h5, 1, 0, 0, 0);
        step("R2 low bits msr",  1, 0, {3'd1, 58'h1B, 3'b111}, 8, 0, 1, 16'h1B);
        // R3 identification and unrecognized spaces
        step("R3 ident",         1, 0, {3'd0, 58'h4, 3'b0}, 4, 0, 0, 0);
        step("R3 space5",        1, 0, {3'd5, 58'hCF8, 3'b0}, 4, 0, 0, 0);
        step("R3 space7 wr",     1, 1, {3'd7, 58'hCF8, 3'b0}, 4, 32'h8000_0000, 0, 0);
        step("R7 R3 after wr",   1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        // R8 / R9 register space
        step("R8 msr unmapped",  1, 0, {3'd1, 58'hC000_0080, 3'b0}, 8, 0, 0, 0);
        step("R9 msr mapped",    1, 0, {3'd1, 58'hC000_0080, 3'b0}, 8, 0, 1, 16'hFFFF);
        // R1 reset clears a loaded register
        step("R10 reload",       1, 1, io_addr(58'hCF8), 4, 32'hFFFF_FFFF, 0, 0);
        step("R6 reload window", 1, 0, io_addr(58'hCFF), 1, 0, 0, 0);
        @(negedge clk) rst = 1'b1;
        req_valid = 0; req_write = 0;
        @(negedge clk) rst = 1'b0;
        mcfg = '0;
        step("R1 after reset",   1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        step("R11 idle end",     0, 1, io_addr(58'hCF8), 4, 32'h8000_0000, 1, 16'h5);
        step("R7 R11 no load",   1, 0, io_addr(58'hCFC), 4, 0, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule